// File: doc/BRIEF.md
# Local Interrupt Countdown Timer

This block is a per-core countdown timer whose expiry is turned into an interrupt request under the control of one packed 32-bit control word. Software programs the control word with an interrupt vector, a delivery mode, a trigger-mode bit, a mask bit and a periodic bit. It then writes a start value into the initial-count register. The current-count register takes that value and drops by one on every prescale tick. The tick rate is fixed by the `PRESCALE` parameter.

When the count steps from one to zero, the block has expired. If the mask bit is clear, it emits a single-cycle request strobe carrying the vector, the delivery mode and the trigger bit that the control word held at that moment. After expiry, a one-shot timer rests at zero. A periodic timer reloads from the initial count and keeps running.

Registers are reached through a simple word-addressed port with a write strobe and a combinational read. Address 0 is the control word, address 1 is the initial count, address 2 is the current count (read only), and address 3 reads as zero.

Top module: `lvt_timer`

## Requirements
- R1: After reset, the control word reads 0x0001_0000 (masked), both count registers read 0, and the request strobe is low.
- R2: Control-word layout: bits 7:0 are the vector, bits 10:8 are the delivery mode, bits 17:12 store status, polarity, remote-pending, trigger (bit 15, level when set), mask (bit 16) and periodic (bit 17). Bits 31:18 and bit 11 read as zero whatever is written, so writing all ones reads back 0x0003_F7FF.
- R3: A write to address 1 loads both the initial count and the current count with the written value on that clock edge. A written value of zero leaves the timer stopped with no further requests.
- R4: While it is nonzero, the current count decreases by exactly one every `PRESCALE` clocks, counted from the initial-count write. The first decrement lands `PRESCALE` edges after the write edge.
- R5: On an unmasked expiry, `irq_valid` is high for exactly one cycle, in the cycle right after the edge at which the count reaches zero. During that cycle `irq_vector`, `irq_mode` and `irq_level` carry control-word bits 7:0, 10:8 and 15.
- R6: When control-word bit 16 is set, an expiry produces no strobe, although the count still expires.
- R7: With bit 17 clear (one-shot), the count stays at zero after expiry until a new initial count is written, and no further request follows.
- R8: With bit 17 set (periodic), expiry reloads the current count from the initial count, so requests repeat every initial-count × `PRESCALE` clocks.
- R9: If an initial-count write lands on the same edge as an expiry, the expiry still gives exactly one strobe, and counting restarts from the newly written value.
- R10: Writes to address 2 (current count) have no effect on either count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| irq_valid | output | 1 | One-cycle interrupt request strobe |
| irq_vector | output | 8 | Vector of the request |
| irq_mode | output | 3 | Delivery mode of the request |
| irq_level | output | 1 | Trigger mode of the request (1 = level) |

## Verification
Two functions can fall on the same edge: a periodic expiry with its automatic reload, and a software write of a new initial count. The bench provokes the collision by tracking the absolute cycle of each write, computing the expiry edge, and driving the write so that it lands on exactly that edge. It then expects one request at the expiry cycle and the next request a full new-count period after the collision edge. Any extra strobe, missing strobe or mistimed strobe is caught by the scoreboard, which compares the cycle number as well as the payload.

// File: rtl/lvt_timer_pkg.sv
// Package: shared types and constants of the local interrupt timer.
package lvt_timer_pkg;

    // Control word, most significant field first (32 bits).
    typedef struct packed {
        logic [13:0] rsv_hi;
        logic        periodic;
        logic        masked;
        logic        level;
        logic        remote_pend;
        logic        polarity;
        logic        busy;
        logic        rsv_11;
        logic [2:0]  mode;
        logic [7:0]  vector;
    } ctl_word_t;

    localparam logic [31:0] CTL_WRITABLE = 32'h0003_F7FF;
    localparam logic [31:0] CTL_RESET    = 32'h0001_0000;

    typedef enum logic [1:0] {
        A_CTL  = 2'd0,
        A_INIT = 2'd1,
        A_CUR  = 2'd2,
        A_NONE = 2'd3
    } reg_addr_e;

endpackage

// File: rtl/lvt_ctl_reg.sv
// Module: lvt_ctl_reg
// Holds the packed control word. Reserved bits are forced to zero on
// write, so they always read as zero. Assumes one write strobe per cycle.
module lvt_ctl_reg
    import lvt_timer_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output ctl_word_t   ctl
);
    // Store the writable bits of the control word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl <= ctl_word_t'(CTL_RESET);
        else if (we)
            ctl <= ctl_word_t'(wdata & CTL_WRITABLE);
    end
endmodule

// File: rtl/lvt_prescaler.sv
// Module: lvt_prescaler
// Produces a one-cycle tick every PRESCALE clocks. A restart realigns the
// phase so that the first tick after it comes PRESCALE-1 cycles later.
// Assumes PRESCALE >= 1; with 1 the tick is always high.
module lvt_prescaler #(
    parameter int PRESCALE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] phase;

    assign tick = (phase == LAST);

    // Advance the phase counter, wrapping at LAST, and clear it on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            phase <= '0;
        else if (tick)
            phase <= '0;
        else
            phase <= phase + CW'(1);
    end
endmodule

// File: rtl/lvt_countdown.sv
// Module: lvt_countdown
// Keeps the initial and current counts. A load sets both. On a tick, a
// nonzero count decrements. The step from 1 to 0 is an expiry, after which
// a periodic timer reloads the initial count. A load has priority over the
// count update, but expire_o still reports an expiry on the same edge.
module lvt_countdown #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    input  logic             periodic,
    output logic [CNT_W-1:0] cur_o,
    output logic [CNT_W-1:0] init_o,
    output logic             expire_o
);
    assign expire_o = tick && (cur_o == CNT_W'(1));

    // Hold the initial count, which only a load changes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            init_o <= '0;
        else if (load)
            init_o <= load_val;
    end

    // Update the current count: load, reload or stop at expiry, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_o <= '0;
        else if (load)
            cur_o <= load_val;
        else if (expire_o)
            cur_o <= periodic ? init_o : '0;
        else if (tick && cur_o != '0)
            cur_o <= cur_o - CNT_W'(1);
    end
endmodule

// File: rtl/lvt_timer.sv
// Module: lvt_timer (top)
// Countdown timer with a packed control word that gates and formats the
// interrupt request raised at expiry. Register reads are combinational.
// Assumes CNT_W <= 32.
module lvt_timer
    import lvt_timer_pkg::*;
#(
    parameter int PRESCALE = 4,
    parameter int CNT_W    = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_valid,
    output logic [7:0]  irq_vector,
    output logic [2:0]  irq_mode,
    output logic        irq_level
);
    ctl_word_t        ctl_q;
    logic             ctl_wr;
    logic             init_wr;
    logic             tick;
    logic             expire;
    logic [CNT_W-1:0] cur_cnt;
    logic [CNT_W-1:0] init_cnt;

    assign ctl_wr  = reg_we && (reg_addr == A_CTL);
    assign init_wr = reg_we && (reg_addr == A_INIT);

    lvt_ctl_reg u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_wr),
        .wdata (reg_wdata),
        .ctl   (ctl_q)
    );

    lvt_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (init_wr),
        .tick    (tick)
    );

    lvt_countdown #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (init_wr),
        .load_val (reg_wdata[CNT_W-1:0]),
        .tick     (tick),
        .periodic (ctl_q.periodic),
        .cur_o    (cur_cnt),
        .init_o   (init_cnt),
        .expire_o (expire)
    );

    // Raise the request strobe for one cycle per unmasked expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_valid <= 1'b0;
        else
            irq_valid <= expire && !ctl_q.masked;
    end

    // Capture the request payload from the control word at expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_vector <= '0;
            irq_mode   <= '0;
            irq_level  <= 1'b0;
        end else if (expire) begin
            irq_vector <= ctl_q.vector;
            irq_mode   <= ctl_q.mode;
            irq_level  <= ctl_q.level;
        end
    end

    // Select the register addressed on the read port.
    always_comb begin
        case (reg_addr)
            A_CTL:   reg_rdata = 32'(ctl_q);
            A_INIT:  reg_rdata = 32'(init_cnt);
            A_CUR:   reg_rdata = 32'(cur_cnt);
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lvt_timer_chk.sv
// Module: lvt_timer_chk
// Property checker for lvt_timer, attached through the bind below.
module lvt_timer_chk #(
    parameter int PRESCALE = 4,
    parameter int CNT_W    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_wr,
    input logic [CNT_W-1:0] wdata,
    input logic [14:0]      rdata_rsv,
    input logic             rd_ctl,
    input logic             irq_valid,
    input logic             masked,
    input logic             periodic,
    input logic [CNT_W-1:0] cur_cnt,
    input logic [CNT_W-1:0] init_cnt
);
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctl |-> rdata_rsv == '0);

    a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
        init_wr |=> cur_cnt == $past(wdata));

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_wr && cur_cnt > CNT_W'(1)) |=>
        (cur_cnt == $past(cur_cnt) || cur_cnt == $past(cur_cnt) - CNT_W'(1)));

    a_r6_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> !$past(masked));

    a_r7_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_cnt == '0 && !init_wr) |=> cur_cnt == '0);

    a_r7_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !$past(init_wr) && !$past(periodic)) |-> cur_cnt == '0);

    a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !$past(init_wr) && $past(periodic)) |-> cur_cnt == init_cnt);

    generate
        if (PRESCALE > 1) begin : g_single
            a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
                irq_valid |=> !irq_valid);
        end
    endgenerate
endmodule

bind lvt_timer lvt_timer_chk #(.PRESCALE(PRESCALE), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init_wr   (init_wr),
    .wdata     (reg_wdata[CNT_W-1:0]),
    .rdata_rsv ({reg_rdata[31:18], reg_rdata[11]}),
    .rd_ctl    (reg_addr == 2'd0),
    .irq_valid (irq_valid),
    .masked    (ctl_q.masked),
    .periodic  (ctl_q.periodic),
    .cur_cnt   (cur_cnt),
    .init_cnt  (init_cnt)
);

// File: tb/lvt_timer_bench.sv
// Scoreboard bench: tasks push expected requests (cycle and payload) into a
// queue; a monitor pops and compares on every observed strobe.
module lvt_timer_bench;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_valid;
    logic [7:0]  irq_vector;
    logic [2:0]  irq_mode;
    logic        irq_level;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int wcyc = 0;
    logic [43:0] expq[$];   // {cycle[31:0], level, mode[2:0], vector[7:0]}

    lvt_timer #(.PRESCALE(P), .CNT_W(32)) u_lvt_timer (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
        .irq_vector(irq_vector), .irq_mode(irq_mode), .irq_level(irq_level)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare each strobe against the head of the queue.
    always @(negedge clk) begin
        if (rst_n && irq_valid) begin
            total++;
            if (expq.size() == 0) begin
                bad++;
                $display("FAIL R5/R6/R7: unexpected request at cycle %0d vec=%h, expected none", cyc, irq_vector);
            end else begin
                logic [43:0] e;
                e = expq.pop_front();
                if (e != {cyc[31:0], irq_level, irq_mode, irq_vector}) begin
                    bad++;
                    $display("FAIL R5/R8/R9: request got cyc=%0d lvl=%b mode=%0d vec=%h, expected cyc=%0d lvl=%b mode=%0d vec=%h",
                             cyc, irq_level, irq_mode, irq_vector, e[43:12], e[11], e[10:8], e[7:0]);
                end
            end
        end
    end

    task automatic expect_irq(input int c, input logic [7:0] v, input logic [2:0] m, input logic l);
        expq.push_back({c[31:0], l, m, v});
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Drive a write now; it lands on the next rising edge, recorded in wcyc.
    task automatic wr_now(input logic [1:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        wcyc = cyc;
        reg_we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic rd_at(input int c, input logic [1:0] a, input logic [31:0] exp, input string tag);
        wait_until(c);
        reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        #2_000_000;
        bad++;
        $display("FAIL watchdog: run did not complete");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int e0;
        int e1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_at(cyc, 2'd0, 32'h0001_0000, "R1 ctl reset");
        rd_at(cyc, 2'd1, 32'h0, "R1 init reset");
        rd_at(cyc, 2'd2, 32'h0, "R1 cur reset");
        chk("R1 strobe low", {31'b0, irq_valid}, 32'h0);
        // R2 reserved bits
        wr(2'd0, 32'hFFFF_FFFF);
        rd_at(cyc, 2'd0, 32'h0003_F7FF, "R2 reserved read zero");
        wr(2'd0, 32'h0000_0000);
        rd_at(cyc, 2'd0, 32'h0, "R2 clear");
        rd_at(cyc, 3'd3, 32'h0, "R2 unused address");
        // R10 write to current count while idle
        wr(2'd2, 32'h55);
        rd_at(cyc, 2'd2, 32'h0, "R10 idle cur write ignored");

        // One-shot: vector 0x41, mode 4, level, unmasked
        wr(2'd0, 32'h0000_8441);
        wr(2'd1, 32'd5);
        e0 = wcyc;
        expect_irq(e0 + 5*P, 8'h41, 3'd4, 1'b1);
        rd_at(e0, 2'd2, 32'd5, "R3 load current");
        rd_at(e0 + P - 1, 2'd2, 32'd5, "R4 before first tick");
        rd_at(e0 + P, 2'd2, 32'd4, "R4 first tick");
        wait_until(e0 + 5);
        wr_now(2'd2, 32'd99);
        rd_at(e0 + 2*P - 1, 2'd2, 32'd4, "R10 cur write ignored while counting");
        rd_at(e0 + 2*P, 2'd2, 32'd3, "R4 second tick");
        rd_at(e0 + 5*P, 2'd2, 32'd0, "R5 count zero at expiry");
        chk("R5 strobe at expiry", {31'b0, irq_valid}, 32'h1);
        rd_at(e0 + 5*P + 1, 2'd2, 32'd0, "R5 strobe gone next cycle");
        chk("R5 one cycle", {31'b0, irq_valid}, 32'h0);
        rd_at(e0 + 5*P + 40, 2'd2, 32'd0, "R7 one-shot holds zero");
        rd_at(cyc, 2'd1, 32'd5, "R7 initial count kept");

        // R6 masked expiry
        wr(2'd0, 32'h0001_0077);
        wr(2'd1, 32'd3);
        e0 = wcyc;
        rd_at(e0 + 3*P, 2'd2, 32'd0, "R6 masked count expires");
        chk("R6 no strobe", {31'b0, irq_valid}, 32'h0);
        rd_at(e0 + 3*P + 8, 2'd2, 32'd0, "R6 stays idle");

        // R8 periodic, edge-triggered, vector 0x22 mode 0
        wr(2'd0, 32'h0002_0022);
        wr(2'd1, 32'd3);
        e0 = wcyc;
        expect_irq(e0 + 3*P, 8'h22, 3'd0, 1'b0);
        expect_irq(e0 + 6*P, 8'h22, 3'd0, 1'b0);
        expect_irq(e0 + 9*P, 8'h22, 3'd0, 1'b0);
        rd_at(e0 + 3*P, 2'd2, 32'd3, "R8 reload after expiry");
        rd_at(e0 + 6*P + P, 2'd2, 32'd2, "R8 counting second period");
        wait_until(e0 + 9*P + 2);
        wr_now(2'd1, 32'd0);
        rd_at(wcyc, 2'd2, 32'd0, "R3 zero write stops");
        rd_at(wcyc + 10*P, 2'd2, 32'd0, "R3 stopped stays zero");
        chk("R8 queue drained", expq.size(), 32'd0);

        // R9 reload write on the expiry edge, vector 0x99 mode 1
        wr(2'd0, 32'h0002_0199);
        wr(2'd1, 32'd4);
        e0 = wcyc;
        expect_irq(e0 + 4*P, 8'h99, 3'd1, 1'b0);
        wait_until(e0 + 4*P - 1);
        wr_now(2'd1, 32'd6);
        e1 = wcyc;
        chk("R9 collision edge", e1, e0 + 4*P);
        expect_irq(e1 + 6*P, 8'h99, 3'd1, 1'b0);
        rd_at(e1, 2'd2, 32'd6, "R9 new value loaded");
        chk("R9 strobe at collision", {31'b0, irq_valid}, 32'h1);
        rd_at(e1 + 1, 2'd2, 32'd6, "R9 single strobe");
        chk("R9 strobe dropped", {31'b0, irq_valid}, 32'h0);
        rd_at(e1 + 6*P, 2'd2, 32'd6, "R9 next period from new value");
        wait_until(e1 + 6*P + 2);
        wr_now(2'd1, 32'd0);
        wr(2'd0, 32'h0001_0000);
        repeat (10) @(negedge clk);
        chk("R9 queue drained", expq.size(), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule